// File: doc/BRIEF.md
# Self-Timed Programming Controller with Write Protection

This block sits behind a serial command decoder in a small non-volatile memory. The decoder hands it already-decoded commands on a strobed port. The block holds a write-enable latch and runs four programming commands on an internal word array: write one word, erase one word, write every word, and erase every word. A programming command is only held as pending when it is strobed. The self-timed cycle begins on the next falling edge of chip select, and the array is updated when the cycle ends.

While a cycle runs, the host can raise chip select again to poll. After a settling delay counted from the falling edge, the block drives a ready/busy bit and raises a status-valid flag. The ready/busy bit is low while the cycle is still running and high once it is done. The status is not offered if chip select returns high only after the cycle has finished. A rising serial clock sampled with chip select and data-in both high clears the status. A combinational read port exposes any word of the array.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset the write-enable latch is clear, status-valid is low and every word of the array reads all ones.
- R2: Opcode 1 (enable) sets the write-enable latch and opcode 2 (disable) clears it. A programming command strobed while the latch is clear leaves the array unchanged.
- R3: An accepted programming command starts its cycle on the next falling edge of `cs`. The array change becomes visible PROG_CYCLES clock cycles after that edge.
- R4: Opcode 3 writes `cmd_data` into the word at `cmd_addr`. Opcode 4 sets every bit of the word at `cmd_addr` to 1.
- R5: Opcode 5 writes `cmd_data` into every word. Opcode 6 sets every bit of the array to 1.
- R6: If `cs` rises while the cycle is running, then once TCS_CYCLES cycles have passed since the starting fall, `stat_vld` is high for as long as `cs` stays high. `rdy` is then 0 until the cycle ends and 1 after it ends.
- R7: `stat_vld` stays low before TCS_CYCLES cycles have passed since the starting fall, and it is low whenever `cs` is low.
- R8: If `cs` first rises only after the cycle has ended, no status is shown.
- R9: A clock cycle with `sk_rise`, `cs` and `din` all high clears the status, so `stat_vld` is low afterwards.
- R10: Every strobe received while a cycle runs is ignored. This includes the enable and disable opcodes.
- R11: Opcodes 0 and 7 have no effect on the latch, the array or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Decoded opcode |
| cmd_addr | input | AW | Word address |
| cmd_data | input | DW | Data pattern |
| cs | input | 1 | Chip-select level |
| sk_rise | input | 1 | Pulse marking a rising serial clock edge |
| din | input | 1 | Serial data-in level |
| rd_addr | input | AW | Read port address |
| rd_data | output | DW | Word at rd_addr |
| rdy | output | 1 | Ready/busy bit, valid when stat_vld is high |
| stat_vld | output | 1 | Status is driven (low means high impedance) |

## Verification
On every cycle, the assertions check the following. A cycle never starts without the write-enable latch set, and it starts only right after a falling edge of chip select. Strobes seen while busy leave the latch untouched. Status is never valid with chip select low, and the clear combination removes it by the next cycle. Other behaviour depends on where the host's edges fall against the running cycle, and only the bench scenarios can show it. This covers an early rise held off until the settling delay, a late rise that shows nothing, the ready transition at cycle end, and the effect of each command on the array.

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl #(
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 20,
  parameter int TCS_CYCLES  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cs,
  input  logic          sk_rise,
  input  logic          din,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          stat_vld
);
  localparam int WORDS = 1 << AW;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam int SW    = $clog2(TCS_CYCLES + 1);

  localparam logic [2:0] OP_EN    = 3'd1;
  localparam logic [2:0] OP_DIS   = 3'd2;
  localparam logic [2:0] OP_WORD  = 3'd3;
  localparam logic [2:0] OP_CLR   = 3'd4;
  localparam logic [2:0] OP_FILL  = 3'd5;
  localparam logic [2:0] OP_CLRALL = 3'd6;

  logic [DW-1:0] mem [WORDS];
  logic          wen, pend, busy, armed, show, cs_q;
  logic [2:0]    pend_op;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic [CW-1:0] cnt;
  logic [SW-1:0] since;

  wire cs_fall  = cs_q & ~cs;
  wire cs_rise  = cs & ~cs_q;
  wire start    = cs_fall & pend & wen & ~busy;
  wire finish   = busy & (cnt == '0);
  wire is_prog  = (cmd_op >= OP_WORD) && (cmd_op <= OP_CLRALL);
  wire take_cmd = cmd_valid & ~busy;
  wire clr_stat = sk_rise & cs & din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen       <= 1'b0;
      pend      <= 1'b0;
      pend_op   <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      armed     <= 1'b0;
      show      <= 1'b0;
      since     <= '0;
      cs_q      <= 1'b0;
    end else begin
      cs_q <= cs;
      if (take_cmd) begin
        if (cmd_op == OP_EN) wen <= 1'b1;
        if (cmd_op == OP_DIS) begin
          wen  <= 1'b0;
          pend <= 1'b0;
        end
        if (is_prog && wen) begin
          pend      <= 1'b1;
          pend_op   <= cmd_op;
          pend_addr <= cmd_addr;
          pend_data <= cmd_data;
        end
      end
      if (start) begin
        pend  <= 1'b0;
        busy  <= 1'b1;
        cnt   <= CW'(PROG_CYCLES - 1);
        armed <= 1'b1;
        since <= '0;
      end else if (since < SW'(TCS_CYCLES)) begin
        since <= since + SW'(1);
      end
      if (cs_fall) show <= 1'b0;
      if (cs_rise && armed) begin
        armed <= 1'b0;
        show  <= busy;
      end
      if (clr_stat) show <= 1'b0;
      if (busy) begin
        if (finish) busy <= 1'b0;
        else        cnt  <= cnt - CW'(1);
      end
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    wire hit = (pend_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '1;
      else if (finish) begin
        case (pend_op)
          OP_WORD:   if (hit) mem[i] <= pend_data;
          OP_CLR:    if (hit) mem[i] <= '1;
          OP_FILL:   mem[i] <= pend_data;
          OP_CLRALL: mem[i] <= '1;
          default:   ;
        endcase
      end
    end
  end

  assign rd_data  = mem[rd_addr];
  assign stat_vld = show & cs & (since >= SW'(TCS_CYCLES));
  assign rdy      = stat_vld & ~busy;
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic din,
  input logic sk_rise,
  input logic cmd_valid,
  input logic stat_vld,
  input logic busy,
  input logic wen
);
  assert_start_needs_wen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  assert_start_on_cs_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cs, 2) && !$past(cs)));

  assert_no_status_cs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !stat_vld);

  assert_clear_combo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_rise && cs && din && stat_vld) |=> !stat_vld);

  assert_busy_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(wen));
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .din(din), .sk_rise(sk_rise),
  .cmd_valid(cmd_valid), .stat_vld(stat_vld), .busy(busy), .wen(wen)
);

// File: tb/nvm_prog_ctrl_tb.sv
module nvm_prog_ctrl_tb;
  localparam int AW = 4, DW = 16, PROG = 20, TCS = 3, WORDS = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cs = 0, sk_rise = 0, din = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [DW-1:0] cmd_data = 0;
  logic [DW-1:0] rd_data;
  logic rdy, stat_vld;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nvm_prog_ctrl #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG), .TCS_CYCLES(TCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs), .sk_rise(sk_rise),
    .din(din), .rd_addr(rd_addr), .rd_data(rd_data), .rdy(rdy), .stat_vld(stat_vld));

  // behavioural reference
  logic [DW-1:0] m_mem [WORDS];
  bit m_wen, m_pend, m_busy, m_armed, m_show, m_csq;
  int m_op, m_addr, m_left, m_since;
  logic [DW-1:0] m_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
      m_wen = 0; m_pend = 0; m_busy = 0; m_armed = 0; m_show = 0; m_csq = 0;
      m_since = 0; m_left = 0;
    end else begin
      bit was_busy, fall, rise;
      was_busy = m_busy;
      fall = m_csq && !cs;
      rise = cs && !m_csq;
      m_csq = cs;
      if (was_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          case (m_op)
            3: m_mem[m_addr] = m_data;
            4: m_mem[m_addr] = '1;
            5: for (int i = 0; i < WORDS; i++) m_mem[i] = m_data;
            6: for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
            default: ;
          endcase
        end
      end
      if (fall && m_pend && m_wen && !was_busy) begin
        m_pend = 0; m_busy = 1; m_left = PROG; m_armed = 1; m_since = 0;
      end else if (m_since < TCS) m_since++;
      if (cmd_valid && !was_busy) begin
        if (cmd_op == 1) m_wen = 1;
        else if (cmd_op == 2) begin m_wen = 0; m_pend = 0; end
        else if (cmd_op >= 3 && cmd_op <= 6 && m_wen) begin
          m_pend = 1; m_op = cmd_op; m_addr = cmd_addr; m_data = cmd_data;
        end
      end
      if (fall) m_show = 0;
      if (rise && m_armed) begin m_armed = 0; m_show = was_busy; end
      if (sk_rise && cs && din) m_show = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit ev;
    ev = m_show && cs && (m_since >= TCS);
    check(stat_vld === ev, "R6/R7 stat_vld per cycle", int'(stat_vld), int'(ev));
    check(rdy === (ev && !m_busy), "R6 rdy per cycle", int'(rdy), int'(ev && !m_busy));
    check(rd_data === m_mem[rd_addr], "R3 rd_data per cycle", int'(rd_data), int'(m_mem[rd_addr]));
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic cmd(input logic [2:0] op, input int a, input logic [DW-1:0] d);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(a); cmd_data = d;
    step();
    cmd_valid = 0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
    rd_addr = AW'(a); #1;
    check(rd_data === exp, req, int'(rd_data), int'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R1: reset state
    check(stat_vld === 0, "R1 stat_vld after reset", int'(stat_vld), 0);
    for (int i = 0; i < WORDS; i++) rd(i, 16'hFFFF, "R1 word all ones");

    // R2: write without enable ignored
    cs = 1; step();
    cmd(3, 3, 16'h1234);
    cs = 0; step();
    cs = 1; step(TCS + 2);
    check(stat_vld === 0, "R2 no cycle while disabled", int'(stat_vld), 0);
    step(PROG);
    rd(3, 16'hFFFF, "R2 write ignored when disabled");

    // R4/R6/R7/R9: enabled write, early poll
    cmd(1, 0, 0);
    cmd(3, 3, 16'h1234);
    cs = 0; step();
    cs = 1; step();
    check(stat_vld === 0, "R7 status held off before delay", int'(stat_vld), 0);
    step(TCS - 1);
    check(stat_vld === 1 && rdy === 0, "R6 busy status", int'({stat_vld, rdy}), 2);
    rd(3, 16'hFFFF, "R3 array unchanged mid cycle");
    step(PROG);
    check(stat_vld === 1 && rdy === 1, "R6 ready status", int'({stat_vld, rdy}), 3);
    rd(3, 16'h1234, "R4 word written");
    rd(2, 16'hFFFF, "R4 neighbour untouched");
    sk_rise = 1; din = 1; step();
    sk_rise = 0; din = 0;
    check(stat_vld === 0, "R9 status cleared", int'(stat_vld), 0);

    // R8/R4: erase with late poll
    cmd(4, 3, 0);
    cs = 0; step(PROG + 4);
    cs = 1; step(2);
    check(stat_vld === 0, "R8 late rise shows nothing", int'(stat_vld), 0);
    rd(3, 16'hFFFF, "R4 word erased");

    // R5/R10: fill all, disable during busy ignored
    cmd(5, 0, 16'hA5C3);
    cs = 0; step(2);
    cmd(2, 0, 0);
    cmd(3, 7, 16'h0001);
    step(PROG);
    for (int i = 0; i < WORDS; i++) rd(i, 16'hA5C3, "R5 every word filled");
    cs = 1; step();
    cmd(3, 7, 16'h7777);
    cs = 0; step(PROG + 2);
    rd(7, 16'h7777, "R10 latch kept through busy strobe");

    // R11: undefined opcodes
    cs = 1; step();
    cmd(0, 1, 16'h0);
    cmd(7, 1, 16'h0);
    cs = 0; step();
    cs = 1; step(TCS + PROG);
    check(stat_vld === 0, "R11 no cycle from undefined op", int'(stat_vld), 0);
    rd(1, 16'hA5C3, "R11 array unchanged");

    // R5: erase all
    cmd(6, 0, 0);
    cs = 0; step(PROG + 2);
    for (int i = 0; i < WORDS; i++) rd(i, 16'hFFFF, "R5 array erased");

    // R2: disable then write ignored
    cs = 1; step();
    cmd(2, 0, 0);
    cmd(3, 5, 16'h5555);
    cs = 0; step(PROG + 2);
    rd(5, 16'hFFFF, "R2 write after disable ignored");

    finish_run();
  end
endmodule